// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block follows a chain of transmit descriptors held in system memory and turns each one into a series of fragment requests for a separate data mover. It reads every field it needs through a single-word memory master. For each descriptor it takes a configuration word, a packet length, a fragment count, and a pointer and a length for each fragment. After the last fragment it writes a completion status into the first word of the descriptor. It then either follows the link word to the next descriptor or stops.

A pulse on `start` loads the first descriptor pointer. The walk stops when a link word has its end-of-chain flag set. It also stops when `halt` is high at the moment the status write completes; in that case the link word is never fetched and the current pointer still refers to the finished descriptor. Memory can be laid out as 16-bit or 32-bit words, with either byte order. A configuration bit can ask for an interrupt pulse for a packet.

Top module: `txdesc_walker`

## Requirements
- R1: After reset `busy`, `mem_req`, `frag_valid`, `irq` and `done` are low.
- R2: A descriptor at pointer P is laid out by word offset from P: 0 is status, 1 is configuration, 2 is packet length, 3 is fragment count. P is the walk pointer with bit 0 cleared, placed under the high address half `desc_hi`.
- R3: A word offset k maps to byte address P + 2k when `wide` is low and P + 4k when `wide` is high. In 32-bit mode the 16-bit value sits in the low half of the 32-bit quantity.
- R4: `big` selects byte order. In little-endian mode the lower address holds the low byte. In big-endian mode the higher address of the value holds the low byte. For a 32-bit word in big-endian mode this puts the value in byte lanes 2 and 3.
- R5: Fragment i (counted from 0) has its pointer low half, pointer high half and length at word offsets 4+3i, 5+3i and 6+3i. It is offered once on `frag_addr`/`frag_len`, in ascending order, with `frag_pkt_len` giving the packet length.
- R6: When configuration bit 15 is set, `irq` pulses high for exactly one cycle for that packet. Otherwise it stays low.
- R7: Only bits 15:12 of the configuration are kept. The status written to word 0 is the kept configuration masked to bits 11:0, with bit 0 (packet sent) set. This gives 0x0001.
- R8: Unless halted, the link word at offset 4+3n (n = fragment count) becomes `cur_ptr`. If its bit 0 is set the walk ends; otherwise the next descriptor is fetched from it.
- R9: With `halt` high when the status write is accepted, no link read is made, `cur_ptr` keeps the finished descriptor, and the walk ends.
- R10: A fragment count of zero produces no fragment request, still writes the status, and reads the link from offset 4.
- R11: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ack`.
- R12: A fragment request keeps `frag_valid`, `frag_addr` and `frag_len` stable until `frag_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk at `desc_ptr` |
| desc_ptr | input | 16 | First descriptor pointer |
| desc_hi | input | 16 | Upper address half for all descriptors |
| wide | input | 1 | 1: 32-bit memory words, 0: 16-bit |
| big | input | 1 | 1: big-endian byte order |
| halt | input | 1 | Stop after the current status write |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data, byte lanes by address |
| mem_ack | input | 1 | Access complete, read data valid |
| mem_rdata | input | 32 | Read data, byte lanes by address |
| frag_valid | output | 1 | Fragment request pending |
| frag_ready | input | 1 | Data mover accepts the fragment |
| frag_addr | output | 32 | Fragment byte pointer |
| frag_len | output | 16 | Fragment length |
| frag_pkt_len | output | 16 | Packet length of the descriptor |
| irq | output | 1 | Programmable interrupt pulse |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at walk end |
| cur_ptr | output | 16 | Current descriptor pointer |

## Verification
A wrong word offset counter shows up in the next memory request. The fragments that follow carry pointers and lengths taken from the wrong words, and the status lands in the wrong descriptor. A miscounted fragment index either drops a fragment or reads the link as a pointer. The final `cur_ptr`, and whether the next descriptor was visited, expose this within one packet. Lane or scaling faults change both the fragment values and the addresses of every access from the first read of the walk.

// File: rtl/txdw_pkg.sv
package txdw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PKT, S_CFG, S_SIZE, S_CNT, S_PLO, S_PHI, S_FSZ,
    S_FRAG, S_STAT, S_LINK, S_DONE
  } walk_st_t;

  localparam logic [15:0] CFG_KEEP  = 16'hF000;
  localparam logic [15:0] STAT_KEEP = 16'h0FFF;
  localparam logic [15:0] SENT_FLAG = 16'h0001;
  localparam int          IRQ_BIT   = 15;
  localparam int          END_BIT   = 0;
  localparam int          OFF_CFG   = 1;
endpackage

// File: rtl/txdw_lane.sv
module txdw_lane #(
  parameter int VW = 16,
  parameter int BW = 32
) (
  input  logic          wide,
  input  logic          big,
  input  logic [BW-1:0] rdata,
  input  logic [VW-1:0] wval,
  output logic [VW-1:0] rval,
  output logic [BW-1:0] wdata
);
  localparam int HB = VW / 2;

  always_comb begin
    if (!big) begin
      rval  = rdata[VW-1:0];
      wdata = {{(BW-VW){1'b0}}, wval};
    end else if (wide) begin
      rval  = {rdata[VW+HB-1:VW], rdata[BW-1:VW+HB]};
      wdata = {wval[HB-1:0], wval[VW-1:HB], {(BW-VW){1'b0}}};
    end else begin
      rval  = {rdata[HB-1:0], rdata[VW-1:HB]};
      wdata = {{(BW-VW){1'b0}}, wval[HB-1:0], wval[VW-1:HB]};
    end
  end
endmodule

// File: rtl/txdw_addr.sv
module txdw_addr #(
  parameter int VW = 16,
  parameter int AW = 32
) (
  input  logic [AW-VW-1:0] base_hi,
  input  logic [VW-1:0]    ptr,
  input  logic [VW-1:0]    off,
  input  logic             wide,
  output logic [AW-1:0]    addr
);
  logic [AW-1:0] base;
  logic [AW-1:0] span;

  always_comb begin
    base = {base_hi, ptr[VW-1:1], 1'b0};
    span = wide ? ({{(AW-VW){1'b0}}, off} << 2) : ({{(AW-VW){1'b0}}, off} << 1);
    addr = base + span;
  end
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
  import txdw_pkg::*;
#(
  parameter int VW = 16,
  parameter int AW = 32,
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] desc_ptr,
  input  logic [AW-VW-1:0] desc_hi,
  input  logic          wide,
  input  logic          big,
  input  logic          halt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [BW-1:0] mem_rdata,
  output logic          frag_valid,
  input  logic          frag_ready,
  output logic [AW-1:0] frag_addr,
  output logic [VW-1:0] frag_len,
  output logic [VW-1:0] frag_pkt_len,
  output logic          irq,
  output logic          busy,
  output logic          done,
  output logic [VW-1:0] cur_ptr
);
  walk_st_t      st, st_n;
  logic [VW-1:0] cur, cur_n, wrk, wrk_n, off, off_n;
  logic [VW-1:0] cfg, cfg_n, psz, psz_n, fc, fc_n, idx, idx_n;
  logic [VW-1:0] plo, plo_n, phi, phi_n, fsz, fsz_n;
  logic          irq_q, irq_n;
  logic [VW-1:0] rval, wval, acc_off;

  txdw_lane #(.VW(VW), .BW(BW)) u_lane (
    .wide(wide), .big(big), .rdata(mem_rdata), .wval(wval),
    .rval(rval), .wdata(mem_wdata)
  );

  txdw_addr #(.VW(VW), .AW(AW)) u_addr (
    .base_hi(desc_hi), .ptr(wrk), .off(acc_off), .wide(wide), .addr(mem_addr)
  );

  // Next-state logic
  always_comb begin
    st_n = st;  cur_n = cur;  wrk_n = wrk;  off_n = off;
    cfg_n = cfg; psz_n = psz; fc_n = fc;    idx_n = idx;
    plo_n = plo; phi_n = phi; fsz_n = fsz;  irq_n = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin cur_n = desc_ptr; st_n = S_PKT; end
      S_PKT: begin wrk_n = cur; off_n = VW'(OFF_CFG); st_n = S_CFG; end
      S_CFG: if (mem_ack) begin
        cfg_n = rval & CFG_KEEP; irq_n = rval[IRQ_BIT];
        off_n = off + 1'b1; st_n = S_SIZE;
      end
      S_SIZE: if (mem_ack) begin psz_n = rval; off_n = off + 1'b1; st_n = S_CNT; end
      S_CNT: if (mem_ack) begin
        fc_n = rval; idx_n = '0; off_n = off + 1'b1;
        st_n = (rval == '0) ? S_STAT : S_PLO;
      end
      S_PLO: if (mem_ack) begin plo_n = rval; off_n = off + 1'b1; st_n = S_PHI; end
      S_PHI: if (mem_ack) begin phi_n = rval; off_n = off + 1'b1; st_n = S_FSZ; end
      S_FSZ: if (mem_ack) begin fsz_n = rval; off_n = off + 1'b1; st_n = S_FRAG; end
      S_FRAG: if (frag_ready) begin
        idx_n = idx + 1'b1;
        st_n  = (idx + 1'b1 == fc) ? S_STAT : S_PLO;
      end
      S_STAT: if (mem_ack) st_n = halt ? S_DONE : S_LINK;
      S_LINK: if (mem_ack) begin
        cur_n = rval;
        st_n  = rval[END_BIT] ? S_DONE : S_PKT;
      end
      S_DONE: st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; wrk <= '0; off <= '0; cfg <= '0; psz <= '0;
      fc <= '0; idx <= '0; plo <= '0; phi <= '0; fsz <= '0; irq_q <= 1'b0;
    end else begin
      st <= st_n; cur <= cur_n; wrk <= wrk_n; off <= off_n; cfg <= cfg_n;
      psz <= psz_n; fc <= fc_n; idx <= idx_n; plo <= plo_n; phi <= phi_n;
      fsz <= fsz_n; irq_q <= irq_n;
    end
  end

  always_comb begin
    mem_req = (st inside {S_CFG, S_SIZE, S_CNT, S_PLO, S_PHI, S_FSZ, S_STAT, S_LINK});
    mem_we  = (st == S_STAT);
    acc_off = (st == S_STAT) ? '0 : off;
    wval    = (cfg & STAT_KEEP) | SENT_FLAG;
    frag_valid   = (st == S_FRAG);
    frag_addr    = {phi, plo};
    frag_len     = fsz;
    frag_pkt_len = psz;
    irq     = irq_q;
    busy    = (st != S_IDLE);
    done    = (st == S_DONE);
    cur_ptr = cur;
  end

  // R11: request and its address/direction held until accepted
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R11: write data held until accepted
  p_wdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_ack |=> mem_we && $stable(mem_wdata));
  // R12: fragment offer held until taken
  p_frag_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid && !frag_ready |=> frag_valid && $stable(frag_addr) && $stable(frag_len));
  // R6: interrupt is a single-cycle pulse
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R9: a walk end is followed by idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: tb/txdesc_walker_test.sv
module txdesc_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] desc_ptr = '0;
  logic [15:0] desc_hi = '0;
  logic        wide = 1'b0, big = 1'b0, halt = 1'b0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        frag_valid, frag_ready = 1'b0;
  logic [31:0] frag_addr;
  logic [15:0] frag_len, frag_pkt_len, cur_ptr;
  logic        irq, busy, done;

  int n_chk = 0, n_err = 0;
  logic [7:0]  mem [0:4095];
  logic [31:0] fa [0:7];
  logic [15:0] fl [0:7];
  logic [15:0] fp [0:7];
  int nfrag = 0, nirq = 0, bad_hi = 0, watch_hits = 0;
  logic [31:0] watch_addr = 32'hFFFF_FFFF;

  always #5 clk = ~clk;

  txdesc_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_ptr(desc_ptr), .desc_hi(desc_hi),
    .wide(wide), .big(big), .halt(halt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_addr(frag_addr),
    .frag_len(frag_len), .frag_pkt_len(frag_pkt_len), .irq(irq), .busy(busy),
    .done(done), .cur_ptr(cur_ptr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: answers one access per request, on falling edges
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      logic [11:0] a;
      a = mem_addr[11:0];
      if (mem_addr[31:16] !== desc_hi) bad_hi++;
      if (mem_addr == watch_addr) watch_hits++;
      if (mem_we) begin
        mem[a] <= mem_wdata[7:0];
        mem[a+12'd1] <= mem_wdata[15:8];
        if (wide) begin
          mem[a+12'd2] <= mem_wdata[23:16];
          mem[a+12'd3] <= mem_wdata[31:24];
        end
      end
      mem_rdata <= {mem[a+12'd3], mem[a+12'd2], mem[a+12'd1], mem[a]};
      mem_ack <= 1'b1;
    end
  end

  // fragment consumer and interrupt counter
  always @(negedge clk) begin
    if (irq) nirq++;
    if (frag_ready) frag_ready <= 1'b0;
    else if (frag_valid) begin
      if (nfrag < 8) begin
        fa[nfrag] = frag_addr; fl[nfrag] = frag_len; fp[nfrag] = frag_pkt_len;
      end
      nfrag++;
      frag_ready <= 1'b1;
    end
  end

  function automatic logic [11:0] wa(input logic [15:0] p, input int k);
    return 12'({p[15:1], 1'b0} + (wide ? 4 * k : 2 * k));
  endfunction

  // R3/R4 layout written from the requirement text
  task automatic put16(input logic [15:0] p, input int k, input logic [15:0] v);
    logic [11:0] a;
    a = wa(p, k);
    if (!wide) begin
      mem[a]       = big ? v[15:8] : v[7:0];
      mem[a+12'd1] = big ? v[7:0]  : v[15:8];
    end else if (!big) begin
      mem[a] = v[7:0]; mem[a+12'd1] = v[15:8]; mem[a+12'd2] = 8'h00; mem[a+12'd3] = 8'h00;
    end else begin
      mem[a] = 8'h00; mem[a+12'd1] = 8'h00; mem[a+12'd2] = v[15:8]; mem[a+12'd3] = v[7:0];
    end
  endtask

  function automatic logic [15:0] get16(input logic [15:0] p, input int k);
    logic [11:0] a;
    a = wa(p, k);
    if (!wide) return big ? {mem[a], mem[a+12'd1]} : {mem[a+12'd1], mem[a]};
    return big ? {mem[a+12'd2], mem[a+12'd3]} : {mem[a+12'd1], mem[a]};
  endfunction

  task automatic walk(input logic [15:0] p);
    nfrag = 0; nirq = 0; bad_hi = 0; watch_hits = 0;
    @(negedge clk); desc_ptr = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R1 busy after start", 32'(busy), 32'd1);
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    chk("walk ends", 32'(busy), 32'd0);
    chk("R2 high address half", 32'(bad_hi), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 frag_valid", 32'(frag_valid), 0);
    chk("R1 irq/done", 32'({irq, done}), 0);
  endtask

  task automatic t_narrow_le;
    wide = 0; big = 0; desc_hi = 16'h0000;
    put16(16'h0100, 0, 16'hFFFF); put16(16'h0100, 1, 16'h8ABC);
    put16(16'h0100, 2, 16'h0040); put16(16'h0100, 3, 16'h0002);
    put16(16'h0100, 4, 16'h1234); put16(16'h0100, 5, 16'h00AB); put16(16'h0100, 6, 16'h0010);
    put16(16'h0100, 7, 16'h5678); put16(16'h0100, 8, 16'h00CD); put16(16'h0100, 9, 16'h0030);
    put16(16'h0100, 10, 16'h0301);
    walk(16'h0100);
    chk("R5 fragment count", 32'(nfrag), 2);
    chk("R5 frag0 addr", fa[0], 32'h00AB1234);
    chk("R5 frag0 len", 32'(fl[0]), 32'h10);
    chk("R5 frag1 addr", fa[1], 32'h00CD5678);
    chk("R5 frag1 len", 32'(fl[1]), 32'h30);
    chk("R2 packet length", 32'(fp[0]), 32'h40);
    chk("R6 irq pulses", 32'(nirq), 1);
    chk("R7 status word", 32'(get16(16'h0100, 0)), 32'h0001);
    chk("R8 cur_ptr from link", 32'(cur_ptr), 32'h0301);
  endtask

  task automatic t_wide_be_chain;
    wide = 1; big = 1; desc_hi = 16'h0005;
    put16(16'h0200, 0, 16'hFFFF); put16(16'h0200, 1, 16'h7000);
    put16(16'h0200, 2, 16'h0020); put16(16'h0200, 3, 16'h0001);
    put16(16'h0200, 4, 16'h9000); put16(16'h0200, 5, 16'h0011); put16(16'h0200, 6, 16'h0020);
    put16(16'h0200, 7, 16'h0400);
    put16(16'h0400, 0, 16'hFFFF); put16(16'h0400, 1, 16'h0FFF);
    put16(16'h0400, 2, 16'h0008); put16(16'h0400, 3, 16'h0002);
    put16(16'h0400, 4, 16'h1111); put16(16'h0400, 5, 16'h0022); put16(16'h0400, 6, 16'h0004);
    put16(16'h0400, 7, 16'h2222); put16(16'h0400, 8, 16'h0033); put16(16'h0400, 9, 16'h0006);
    put16(16'h0400, 10, 16'h0601);
    walk(16'h0200);
    chk("R8 chained fragments", 32'(nfrag), 3);
    chk("R4 frag0 addr", fa[0], 32'h00119000);
    chk("R3 frag2 addr", fa[2], 32'h00332222);
    chk("R3 frag2 len", 32'(fl[2]), 32'h6);
    chk("R2 second packet length", 32'(fp[1]), 32'h8);
    chk("R6 no irq", 32'(nirq), 0);
    chk("R7 status first", 32'(get16(16'h0200, 0)), 32'h0001);
    chk("R7 status second", 32'(get16(16'h0400, 0)), 32'h0001);
    chk("R8 cur_ptr end", 32'(cur_ptr), 32'h0601);
  endtask

  task automatic t_zero_frags;
    wide = 0; big = 1; desc_hi = 16'h0000;
    put16(16'h0700, 0, 16'hFFFF); put16(16'h0700, 1, 16'h8000);
    put16(16'h0700, 2, 16'h0000); put16(16'h0700, 3, 16'h0000);
    put16(16'h0700, 4, 16'h0081);
    walk(16'h0700);
    chk("R10 no fragments", 32'(nfrag), 0);
    chk("R10 status written", 32'(get16(16'h0700, 0)), 32'h0001);
    chk("R10 link at word 4", 32'(cur_ptr), 32'h0081);
    chk("R6 irq with zero frags", 32'(nirq), 1);
  endtask

  task automatic t_halt;
    wide = 1; big = 0; desc_hi = 16'h0000; halt = 1;
    put16(16'h0800, 0, 16'hFFFF); put16(16'h0800, 1, 16'h0000);
    put16(16'h0800, 2, 16'h0002); put16(16'h0800, 3, 16'h0001);
    put16(16'h0800, 4, 16'hAAAA); put16(16'h0800, 5, 16'h0000); put16(16'h0800, 6, 16'h0002);
    put16(16'h0800, 7, 16'h0900);
    put16(16'h0900, 0, 16'hFFFF);
    watch_addr = 32'h0000_0800 + 32'd28;
    walk(16'h0800);
    chk("R9 one fragment", 32'(nfrag), 1);
    chk("R9 status written", 32'(get16(16'h0800, 0)), 32'h0001);
    chk("R9 no link read", 32'(watch_hits), 0);
    chk("R9 cur_ptr kept", 32'(cur_ptr), 32'h0800);
    chk("R9 next descriptor untouched", 32'(get16(16'h0900, 0)), 32'hFFFF);
    halt = 0; watch_addr = 32'hFFFF_FFFF;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow_le();
    t_wide_be_chain();
    t_zero_frags();
    t_halt();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule